// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets clocked logic talk to an external 64K x 16 asynchronous static RAM. A requester presents one access at a time on a valid/ready port: a write flag, a word address, write data and two lane-select bits. The controller then runs a short, fixed sequence of registered memory strobes: chip select, write strobe, output enable, the two active-low lane enables and the address. Each phase lasts a whole number of clock cycles, set by parameters, so that access time, write pulse width, setup and hold are all met.

The data path to the memory is split. There is an outgoing data bus with its own drive-enable for the pad tristate, and an incoming data bus. During a write the memory's output enable stays high. The controller's own drivers switch on only after the write strobe has been low for one clock, and they stay on for one clock after the strobe rises. As a result the memory and the controller never drive the bus together.

A read returns the captured word with a one-cycle valid pulse. Bits of any lane that was not selected come back as zero. Between accesses the chip select idles high.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted, and in idle afterwards, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` are high, `mem_dq_oe` is 0, `req_rdy` is 1 and `rsp_vld` is 0. Reset is asynchronous and also aborts an access in progress.
- R2: A request is accepted on a clock edge where `req_vld` and `req_rdy` are both high. `req_rdy` is low from that edge until the edge that releases the last strobe. `mem_ce_n` is high whenever `req_rdy` is high.
- R3: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for exactly RD_CYC cycles, starting in the cycle after acceptance. Lane selects are active-high: `req_be[0]` selects bits 7:0 and drives `mem_lb_n` low, and `req_be[1]` selects bits 15:8 and drives `mem_ub_n` low.
- R4: Read data is captured from `mem_dq_in` on the edge that ends the read. In the next cycle `rsp_vld` is 1 for exactly one cycle, `req_rdy` is 1 and `rsp_data` holds the word. Bits of an unselected lane are 0.
- R5: A write has one setup cycle with `mem_ce_n` low and `mem_we_n` high. Then `mem_we_n` is low for exactly WR_PULSE cycles (values below 2 count as 2). Then there is one recovery cycle with `mem_we_n` high and `mem_ce_n` still low. `mem_oe_n` stays high throughout.
- R6: `mem_dq_oe` is 0 during the first cycle with `mem_we_n` low. It is 1 for the remaining low cycles and for the one cycle after `mem_we_n` rises, and 0 at all other times. While it is 1, `mem_dq_out` carries the request's write data.
- R7: Only the selected lanes of the memory word change on a write. A write with `req_be` = 00 changes nothing, and a read with `req_be` = 00 returns 0.
- R8: `mem_addr`, `mem_ub_n` and `mem_lb_n` do not change during any run of consecutive cycles with `mem_ce_n` low.
- R9: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request valid |
| req_rdy | output | 1 | Controller can accept a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane selects, bit 0 = low byte, bit 1 = high byte |
| rsp_data | output | 16 | Read data, unselected lanes zero |
| rsp_vld | output | 1 | One-cycle read data valid |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_addr | output | 16 | Memory address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
Two situations are hard to reach from the ports. The first is a reset that lands in the middle of a write strobe. The bench starts a write to a fresh address, pulls reset low while the write strobe is low, checks that every strobe and the data drive return to idle at once, and then reads the address back to show the word never changed. The second is lane isolation. The bench's memory model returns a fixed non-zero pattern on any lane that is not enabled, and sequences of partial writes and partial reads to one address make any lane leakage show up in the returned word.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_WSET = 3'd2,
        ST_WLOW = 3'd3,
        ST_WREC = 3'd4
    } seq_st_e;

    localparam int LANE_W = 8;

endpackage

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W/LANE_W-1:0] lane_en,
    input  logic [DATA_W-1:0]        din,
    output logic [DATA_W-1:0]        dout
);
    localparam int LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*LANE_W +: LANE_W] = lane_en[g] ? din[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int RD_CYC   = 3,
    parameter int WR_PULSE = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_vld,
    output logic                     req_rdy,
    input  logic                     req_wr,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W/LANE_W-1:0] req_be,
    input  logic [DATA_W-1:0]        rd_masked,
    output logic [DATA_W/LANE_W-1:0] lane_sel,
    output logic [DATA_W-1:0]        rsp_data,
    output logic                     rsp_vld,
    output logic                     ce_n,
    output logic                     we_n,
    output logic                     oe_n,
    output logic [DATA_W/LANE_W-1:0] be_n,
    output logic [ADDR_W-1:0]        addr,
    output logic [DATA_W-1:0]        dq_out,
    output logic                     dq_oe
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int RC    = (RD_CYC < 1) ? 1 : RD_CYC;
    localparam int WP    = (WR_PULSE < 2) ? 2 : WR_PULSE;
    localparam int CMAX  = (RC > WP) ? RC : WP;
    localparam int CNT_W = $clog2(CMAX + 1);

    typedef struct packed {
        seq_st_e            st;
        logic [CNT_W-1:0]   cnt;
        logic               rdy;
        logic               ce_n;
        logic               we_n;
        logic               oe_n;
        logic               dq_oe;
        logic               rsp_vld;
        logic [LANES-1:0]   be;
        logic [LANES-1:0]   be_n;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rsp_data;
    } seq_s;

    localparam seq_s RESET_V = '{
        st: ST_IDLE, cnt: '0, rdy: 1'b1, ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
        dq_oe: 1'b0, rsp_vld: 1'b0, be: '0, be_n: '1, addr: '0, wdata: '0,
        rsp_data: '0
    };

    seq_s q, d;

    always_comb begin
        d         = q;
        d.rsp_vld = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_vld) begin
                    d.rdy   = 1'b0;
                    d.ce_n  = 1'b0;
                    d.addr  = req_addr;
                    d.be    = req_be;
                    d.be_n  = ~req_be;
                    d.wdata = req_wdata;
                    if (req_wr) begin
                        d.st = ST_WSET;
                    end else begin
                        d.st   = ST_RD;
                        d.oe_n = 1'b0;
                        d.cnt  = CNT_W'(RC - 1);
                    end
                end
            end
            ST_RD: begin
                if (q.cnt == '0) begin
                    d.rsp_data = rd_masked;
                    d.rsp_vld  = 1'b1;
                    d.ce_n     = 1'b1;
                    d.oe_n     = 1'b1;
                    d.be_n     = '1;
                    d.rdy      = 1'b1;
                    d.st       = ST_IDLE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_WSET: begin
                d.we_n = 1'b0;
                d.cnt  = CNT_W'(WP - 1);
                d.st   = ST_WLOW;
            end
            ST_WLOW: begin
                d.dq_oe = 1'b1;
                if (q.cnt == '0) begin
                    d.we_n = 1'b1;
                    d.st   = ST_WREC;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_WREC: begin
                d.dq_oe = 1'b0;
                d.ce_n  = 1'b1;
                d.be_n  = '1;
                d.rdy   = 1'b1;
                d.st    = ST_IDLE;
            end
            default: d = RESET_V;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_V;
        else        q <= d;
    end

    assign req_rdy  = q.rdy;
    assign lane_sel = q.be;
    assign rsp_data = q.rsp_data;
    assign rsp_vld  = q.rsp_vld;
    assign ce_n     = q.ce_n;
    assign we_n     = q.we_n;
    assign oe_n     = q.oe_n;
    assign be_n     = q.be_n;
    assign addr     = q.addr;
    assign dq_out   = q.wdata;
    assign dq_oe    = q.dq_oe;

    // Ready implies the memory is deselected
    p_idle_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_rdy |-> ce_n);

    // Address and lanes held across consecutive selected cycles
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !$past(ce_n)) |-> ($stable(addr) && $stable(be_n)));

    // Pad drivers never fight the memory outputs
    p_no_fight_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

    // Drivers stay off in the first write-strobe cycle
    p_drv_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> !dq_oe);

    // Drivers remain on in the cycle after the write strobe rises
    p_drv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> dq_oe);

    // Write strobe only inside a selected, output-disabled cycle
    p_we_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!ce_n && oe_n));

    // Read response is a single-cycle pulse
    p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |=> !rsp_vld);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int RD_CYC   = 3,
    parameter int WR_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    output logic              req_rdy,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_vld,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int LANES = DATA_W / LANE_W;

    logic [LANES-1:0]  lane_sel;
    logic [LANES-1:0]  be_n;
    logic [DATA_W-1:0] rd_masked;

    sram_lane_mask #(.DATA_W(DATA_W), .LANE_W(LANE_W)) mask_i (
        .lane_en (lane_sel),
        .din     (mem_dq_in),
        .dout    (rd_masked)
    );

    sram_lane_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CYC(RD_CYC), .WR_PULSE(WR_PULSE)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_vld   (req_vld),
        .req_rdy   (req_rdy),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .rd_masked (rd_masked),
        .lane_sel  (lane_sel),
        .rsp_data  (rsp_data),
        .rsp_vld   (rsp_vld),
        .ce_n      (mem_ce_n),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .be_n      (be_n),
        .addr      (mem_addr),
        .dq_out    (mem_dq_out),
        .dq_oe     (mem_dq_oe)
    );

    assign mem_lb_n = be_n[0];
    assign mem_ub_n = be_n[1];

endmodule

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;
    localparam int RD_CYC   = 3;
    localparam int WR_PULSE = 2;
    localparam int NVEC     = 14;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_vld, req_rdy, req_wr;
    logic [15:0] req_addr, req_wdata;
    logic [1:0]  req_be;
    logic [15:0] rsp_data;
    logic        rsp_vld;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n;
    logic [15:0] mem_addr, mem_dq_out, mem_dq_in;
    logic        mem_dq_oe;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sram_lane_ctrl #(.RD_CYC(RD_CYC), .WR_PULSE(WR_PULSE)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_rdy(req_rdy),
        .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_data(rsp_data), .rsp_vld(rsp_vld),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: 64 words, floating lanes read back as 0xDE / 0xAD
    logic [15:0] model [64];
    logic        rd_on;
    assign rd_on     = !mem_ce_n && mem_we_n && !mem_oe_n;
    assign mem_dq_in = {(rd_on && !mem_ub_n) ? model[mem_addr[5:0]][15:8] : 8'hDE,
                        (rd_on && !mem_lb_n) ? model[mem_addr[5:0]][7:0]  : 8'hAD};

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitors: write commit on strobe rise, contention, pulse width, address hold
    logic        prev_we = 1'b1, prev_ce = 1'b1;
    logic [17:0] prev_al = '0;
    int          we_run  = 0;
    logic [15:0] cur_wdata = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we_n && !prev_we && !mem_ce_n) begin
                logic [15:0] v;
                v = mem_dq_oe ? mem_dq_out : 16'hxxxx;
                if (!mem_ub_n) model[mem_addr[5:0]][15:8] = v[15:8];
                if (!mem_lb_n) model[mem_addr[5:0]][7:0]  = v[7:0];
                check(we_run == WR_PULSE, "R5 write strobe width", we_run, WR_PULSE);
            end
            if (mem_dq_oe && !mem_oe_n)
                check(1'b0, "R9 driver overlaps memory output", 1, 0);
            if (mem_dq_oe && mem_dq_out !== cur_wdata)
                check(1'b0, "R6 driven write data", mem_dq_out, cur_wdata);
            if (!mem_ce_n && !prev_ce && {mem_addr, mem_ub_n, mem_lb_n} !== prev_al)
                check(1'b0, "R8 address or lanes moved", {mem_addr, mem_ub_n, mem_lb_n}, prev_al);
            if (req_rdy && !mem_ce_n)
                check(1'b0, "R2 chip select low while ready", 0, 1);
        end
        we_run  = mem_we_n ? 0 : we_run + 1;
        prev_we = mem_we_n;
        prev_ce = mem_ce_n;
        prev_al = {mem_addr, mem_ub_n, mem_lb_n};
    end

    // {wr, be[1:0], addr, wdata, expected read}
    localparam logic [50:0] VEC [NVEC] = '{
        {1'b1, 2'b11, 16'h0010, 16'h1234, 16'h0000},
        {1'b0, 2'b11, 16'h0010, 16'h0000, 16'h1234},
        {1'b1, 2'b01, 16'h0010, 16'hAB99, 16'h0000},
        {1'b0, 2'b11, 16'h0010, 16'h0000, 16'h1299},
        {1'b1, 2'b10, 16'h0010, 16'h77FF, 16'h0000},
        {1'b0, 2'b11, 16'h0010, 16'h0000, 16'h7799},
        {1'b0, 2'b01, 16'h0010, 16'h0000, 16'h0099},
        {1'b0, 2'b10, 16'h0010, 16'h0000, 16'h7700},
        {1'b1, 2'b00, 16'h0010, 16'hFFFF, 16'h0000},
        {1'b0, 2'b11, 16'h0010, 16'h0000, 16'h7799},
        {1'b0, 2'b00, 16'h0010, 16'h0000, 16'h0000},
        {1'b1, 2'b11, 16'hFFFF, 16'h5A5A, 16'h0000},
        {1'b0, 2'b11, 16'hFFFF, 16'h0000, 16'h5A5A},
        {1'b0, 2'b11, 16'h0010, 16'h0000, 16'h7799}
    };

    task automatic run_req(input bit wr, input logic [1:0] be, input logic [15:0] a,
                           input logic [15:0] wd, input logic [15:0] exp);
        int k;
        int done_k;
        done_k = wr ? WR_PULSE + 3 : RD_CYC + 1;
        @(negedge clk);
        check(req_rdy === 1'b1, "R2 ready before request", req_rdy, 1);
        req_vld = 1'b1; req_wr = wr; req_be = be; req_addr = a; req_wdata = wd;
        cur_wdata = wd;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            req_vld = 1'b0;
            if (k == 1) begin
                check(!req_rdy, "R2 ready low after accept", req_rdy, 0);
                check(mem_addr == a && mem_ub_n == !be[1] && mem_lb_n == !be[0],
                      "R3 address and lane enables", {mem_addr, mem_ub_n, mem_lb_n},
                      {a, !be[1], !be[0]});
                if (wr) check({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe} == 4'b0110,
                              "R5 write setup cycle", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0110);
                else    check({mem_ce_n, mem_we_n, mem_oe_n} == 3'b010,
                              "R3 read strobes", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b010);
            end
            if (wr && k == 2)
                check(!mem_we_n && !mem_dq_oe, "R6 drivers off in first strobe cycle",
                      {mem_we_n, mem_dq_oe}, 2'b00);
            if (wr && k == 3)
                check(!mem_we_n && mem_dq_oe, "R6 drivers on later in strobe",
                      {mem_we_n, mem_dq_oe}, 2'b01);
            if (wr && k == WR_PULSE + 2)
                check(mem_we_n && !mem_ce_n && mem_dq_oe, "R5 R6 recovery cycle",
                      {mem_we_n, mem_ce_n, mem_dq_oe}, 3'b101);
            if (!wr && k == RD_CYC)
                check(!mem_ce_n && !mem_oe_n, "R3 read strobes held", {mem_ce_n, mem_oe_n}, 2'b00);
        end while (!req_rdy && k < 20);
        check(k == done_k, "R2 R3 R5 cycles until ready", k, done_k);
        check(mem_ce_n && !mem_dq_oe && mem_oe_n && mem_we_n, "R2 strobes released",
              {mem_ce_n, mem_dq_oe, mem_oe_n, mem_we_n}, 4'b1011);
        if (wr) begin
            check(!rsp_vld, "R4 no response on write", rsp_vld, 0);
        end else begin
            check(rsp_vld && rsp_data == exp, "R4 R7 read data", {rsp_vld, rsp_data}, {1'b1, exp});
            @(negedge clk);
            check(!rsp_vld, "R4 response single cycle", rsp_vld, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 16'h0000;
        rst_n = 1'b0; req_vld = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
        repeat (3) @(negedge clk);
        check({mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_rdy, rsp_vld}
              == 8'b11111010, "R1 reset state",
              {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_rdy, rsp_vld}, 8'b11111010);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_ce_n && req_rdy, "R1 idle after reset", {mem_ce_n, req_rdy}, 2'b11);

        for (int v = 0; v < NVEC; v++)
            run_req(VEC[v][50], VEC[v][49:48], VEC[v][47:32], VEC[v][31:16], VEC[v][15:0]);

        // Reset mid-strobe aborts the write: word at 0x20 stays zero
        @(negedge clk);
        req_vld = 1'b1; req_wr = 1'b1; req_be = 2'b11; req_addr = 16'h0020; req_wdata = 16'hCAFE;
        cur_wdata = 16'hCAFE;
        @(negedge clk); req_vld = 1'b0;
        @(negedge clk);
        check(!mem_we_n, "R5 strobe low before abort", mem_we_n, 0);
        rst_n = 1'b0;
        #1;
        check({mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_rdy}
              == 7'b1111101, "R1 reset aborts access",
              {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_rdy}, 7'b1111101);
        @(negedge clk); rst_n = 1'b1;
        run_req(1'b0, 2'b11, 16'h0020, 16'h0000, 16'h0000);

        // Upper-lane write at a new address leaves the low lane at zero
        run_req(1'b1, 2'b10, 16'h0021, 16'hBEEF, 16'h0000);
        run_req(1'b0, 2'b11, 16'h0021, 16'h0000, 16'hBE00);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule